// File: doc/BRIEF.md
# Nested Loop Test-Vector Sequencer

This block generates the line addresses used to read stored test vectors and presents one address per cycle on a valid/ready stream toward the device under test. A program runs from line 0 through a programmed final line. Up to two nested loop levels can be enabled. Each level replays an address span from its first line to its last line a set number of times before execution moves on. The inner level restarts its full count on every pass of the outer level. Every vector that leaves the block carries a running sequence index.

On the return path, captured output samples arrive together with the sequence index of the input that produced them. They are written to a circular capture store. The write pointer wraps from the last slot back to slot 0. Each stored sample sits next to its index, so outputs stay matched to their inputs even when loops revisit the same lines.

The configuration is taken in with a start pulse and held for the whole run. A configuration that breaks the nesting or range rules is refused and flagged.

Top module: `nested_vec_seq`

## Requirements
- R1: After reset, `busy`, `vec_valid`, `done`, `cfg_err` and `wr_en` are all 0.
- R2: With no loop enabled, a run issues the addresses 0, 1, ... up to `cfg_prog_last`, in order, one address per accepted transfer (`vec_valid && vec_ready`).
- R3: An enabled loop level L (bit L of `cfg_loop_en`; level 0 is inner, level 1 is outer) issues lines `cfg_loop_first[L]`..`cfg_loop_last[L]` a total of `cfg_loop_count[L]` times, then continues at `cfg_loop_last[L]`+1.
- R4: A loop count of 0 behaves exactly like a count of 1.
- R5: When both levels are enabled, the inner loop runs its full count on every outer pass. When both loops end on the same line, the inner repeat is resolved first.
- R6: `vec_idx` is 0 for the first vector of each run and rises by exactly 1 for each accepted vector.
- R7: While `vec_valid` is 1 and `vec_ready` is 0, `vec_addr` and `vec_idx` hold their values. No vector is skipped or repeated.
- R8: `done` is high for exactly one cycle: the cycle after the transfer of the last vector of the program. `busy` and `vec_valid` are 0 in that cycle.
- R9: A start while idle is refused, and `cfg_err` rises while `busy` stays 0, if any enabled level has first > last, or last > `cfg_prog_last`, or if both levels are enabled and the inner span is not inside the outer span. The next accepted start clears `cfg_err`.
- R10: Each cycle with `cap_valid` = 1 produces, one cycle later, `wr_en` = 1 with `wr_data`/`wr_idx` equal to `cap_data`/`cap_idx`. `wr_addr` is 0 for the first write after a start, steps by 1 per write, and wraps from `CAP_DEPTH`-1 to 0.
- R11: A start pulse or a change of configuration inputs while `busy` is 1 has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a run with the present configuration (ignored while busy) |
| cfg_prog_last | input | ADDR_W | Final line of the program |
| cfg_loop_en | input | LEVELS | Enable per loop level (bit 0 inner, bit 1 outer) |
| cfg_loop_first | input | LEVELS×ADDR_W | First line of each loop span |
| cfg_loop_last | input | LEVELS×ADDR_W | Last line of each loop span |
| cfg_loop_count | input | LEVELS×CNT_W | Pass count per loop (0 acts as 1) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse after the final transfer |
| cfg_err | output | 1 | Last start attempt was refused for a bad configuration |
| vec_valid | output | 1 | Address/index on the stream are valid |
| vec_ready | input | 1 | Downstream accepts the current vector |
| vec_addr | output | ADDR_W | Vector store line to read |
| vec_idx | output | IDX_W | Sequence index of the vector |
| cap_valid | input | 1 | Captured output sample present |
| cap_data | input | VEC_W | Captured output sample |
| cap_idx | input | IDX_W | Sequence index of the input behind the sample |
| wr_en | output | 1 | Capture store write strobe |
| wr_addr | output | CAP_AW | Capture store slot |
| wr_data | output | VEC_W | Sample written |
| wr_idx | output | IDX_W | Index written beside the sample |

## Verification
On every cycle, the assertions check the stream contract: the address and index hold while the stream is stalled, and the index steps by one per transfer. They also check that `done` is a single pulse that follows the final transfer, that a refused configuration leaves the block idle, that addresses stay within the program, and that a start while busy keeps the run alive. The actual order of lines (loop replay, count-zero handling, inner-before-outer resolution at a shared end line) and the wrap of the capture pointer with matched indices can only be shown by the bench's scenarios. There, an expanded reference sequence is compared against the stream under random backpressure.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  // A pass count of zero is executed as a single pass.
  function automatic logic [31:0] eff_count(input logic [31:0] c);
    return (c == 32'd0) ? 32'd1 : c;
  endfunction

  // Circular increment for a store of depth d.
  function automatic logic [31:0] wrap_inc(input logic [31:0] p, input logic [31:0] d);
    return ((p + 32'd1) >= d) ? 32'd0 : (p + 32'd1);
  endfunction

  // Span is well formed and lies inside the program.
  function automatic logic span_ok(input logic [31:0] lo, input logic [31:0] hi,
                                   input logic [31:0] limit);
    return (lo <= hi) && (hi <= limit);
  endfunction

  // Inner span [ilo,ihi] lies inside outer span [olo,ohi].
  function automatic logic span_inside(input logic [31:0] ilo, input logic [31:0] ihi,
                                       input logic [31:0] olo, input logic [31:0] ohi);
    return (ilo >= olo) && (ihi <= ohi);
  endfunction

endpackage

// File: rtl/nvs_cfg_check.sv
module nvs_cfg_check
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEVELS = 2
) (
  input  logic [ADDR_W-1:0]              prog_last,
  input  logic [LEVELS-1:0]              loop_en,
  input  logic [LEVELS-1:0][ADDR_W-1:0]  loop_first,
  input  logic [LEVELS-1:0][ADDR_W-1:0]  loop_last,
  output logic                           bad
);

  always_comb begin
    bad = 1'b0;
    for (int i = 0; i < LEVELS; i++) begin
      if (loop_en[i] && !span_ok(32'(loop_first[i]), 32'(loop_last[i]), 32'(prog_last)))
        bad = 1'b1;
      // level i encloses level i-1 whenever both are active
      if (i > 0) begin
        if (loop_en[i] && loop_en[i-1] &&
            !span_inside(32'(loop_first[i-1]), 32'(loop_last[i-1]),
                         32'(loop_first[i]), 32'(loop_last[i])))
          bad = 1'b1;
      end
    end
  end

endmodule

// File: rtl/nvs_loop_level.sv
module nvs_loop_level
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              en_in,
  input  logic [ADDR_W-1:0] first_in,
  input  logic [ADDR_W-1:0] last_in,
  input  logic [CNT_W-1:0]  count_in,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              step,
  input  logic              consider,
  output logic              jump,
  output logic [ADDR_W-1:0] target
);

  logic              en_q;
  logic [ADDR_W-1:0] first_q;
  logic [ADDR_W-1:0] last_q;
  logic [CNT_W-1:0]  count_q;
  logic [CNT_W-1:0]  remain;
  logic              at_end;

  assign at_end = en_q && (cur_addr == last_q);
  assign jump   = at_end && (remain > CNT_W'(1));
  assign target = first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      first_q <= '0;
      last_q  <= '0;
      count_q <= '0;
      remain  <= '0;
    end else if (load) begin
      en_q    <= en_in;
      first_q <= first_in;
      last_q  <= last_in;
      count_q <= CNT_W'(eff_count(32'(count_in)));
      remain  <= CNT_W'(eff_count(32'(count_in)));
    end else if (step && consider && at_end) begin
      // exhausted levels re-arm so that the next enclosing pass sees a full count
      remain <= jump ? (remain - CNT_W'(1)) : count_q;
    end
  end

endmodule

// File: rtl/nvs_capture.sv
module nvs_capture
  import nvs_pkg::*;
#(
  parameter int VEC_W     = 96,
  parameter int IDX_W     = 16,
  parameter int CAP_DEPTH = 12,
  parameter int CAP_AW    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              in_valid,
  input  logic [VEC_W-1:0]  in_data,
  input  logic [IDX_W-1:0]  in_idx,
  output logic              wr_en,
  output logic [CAP_AW-1:0] wr_addr,
  output logic [VEC_W-1:0]  wr_data,
  output logic [IDX_W-1:0]  wr_idx
);

  logic [CAP_AW-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_idx  <= '0;
    end else begin
      wr_en <= in_valid;
      if (in_valid) begin
        wr_addr <= clear ? '0 : ptr;
        wr_data <= in_data;
        wr_idx  <= in_idx;
      end
      if (clear)
        ptr <= in_valid ? CAP_AW'(1) : '0;
      else if (in_valid)
        ptr <= CAP_AW'(wrap_inc(32'(ptr), 32'(CAP_DEPTH)));
    end
  end

endmodule

// File: rtl/nested_vec_seq.sv
module nested_vec_seq
  import nvs_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 8,
  parameter int IDX_W     = 16,
  parameter int VEC_W     = 96,
  parameter int LEVELS    = 2,
  parameter int CAP_DEPTH = 12,
  localparam int CAP_AW   = (CAP_DEPTH > 1) ? $clog2(CAP_DEPTH) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [ADDR_W-1:0]             cfg_prog_last,
  input  logic [LEVELS-1:0]             cfg_loop_en,
  input  logic [LEVELS-1:0][ADDR_W-1:0] cfg_loop_first,
  input  logic [LEVELS-1:0][ADDR_W-1:0] cfg_loop_last,
  input  logic [LEVELS-1:0][CNT_W-1:0]  cfg_loop_count,
  output logic                          busy,
  output logic                          done,
  output logic                          cfg_err,
  output logic                          vec_valid,
  input  logic                          vec_ready,
  output logic [ADDR_W-1:0]             vec_addr,
  output logic [IDX_W-1:0]              vec_idx,
  input  logic                          cap_valid,
  input  logic [VEC_W-1:0]              cap_data,
  input  logic [IDX_W-1:0]              cap_idx,
  output logic                          wr_en,
  output logic [CAP_AW-1:0]             wr_addr,
  output logic [VEC_W-1:0]              wr_data,
  output logic [IDX_W-1:0]              wr_idx
);

  // named internal events (also observed by the bound checker)
  logic                          cfg_bad;
  logic                          launch;
  logic                          hs;
  logic                          take_jump;
  logic                          finish;
  logic [ADDR_W-1:0]             jump_addr;
  logic [ADDR_W-1:0]             next_addr;
  logic [ADDR_W-1:0]             prog_last_q;
  logic [ADDR_W-1:0]             cur_addr;
  logic [IDX_W-1:0]              idx_q;
  logic [LEVELS-1:0]             lvl_jump;
  logic [LEVELS-1:0]             lvl_consider;
  logic [LEVELS-1:0][ADDR_W-1:0] lvl_target;

  nvs_cfg_check #(.ADDR_W(ADDR_W), .LEVELS(LEVELS)) u_cfg_check (
    .prog_last  (cfg_prog_last),
    .loop_en    (cfg_loop_en),
    .loop_first (cfg_loop_first),
    .loop_last  (cfg_loop_last),
    .bad        (cfg_bad)
  );

  assign launch = start && !busy && !cfg_bad;
  assign hs     = busy && vec_ready;

  // innermost level decides first; an outer level only acts when all inner ones fall through
  assign lvl_consider[0] = 1'b1;
  generate
    for (genvar g = 1; g < LEVELS; g++) begin : g_chain
      assign lvl_consider[g] = lvl_consider[g-1] && !lvl_jump[g-1];
    end
    for (genvar g = 0; g < LEVELS; g++) begin : g_level
      nvs_loop_level #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .en_in    (cfg_loop_en[g]),
        .first_in (cfg_loop_first[g]),
        .last_in  (cfg_loop_last[g]),
        .count_in (cfg_loop_count[g]),
        .cur_addr (cur_addr),
        .step     (hs),
        .consider (lvl_consider[g]),
        .jump     (lvl_jump[g]),
        .target   (lvl_target[g])
      );
    end
  endgenerate

  always_comb begin
    take_jump = 1'b0;
    jump_addr = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (!take_jump && lvl_jump[i]) begin
        take_jump = 1'b1;
        jump_addr = lvl_target[i];
      end
    end
  end

  assign finish    = !take_jump && (cur_addr == prog_last_q);
  assign next_addr = take_jump ? jump_addr : (cur_addr + ADDR_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      cfg_err     <= 1'b0;
      cur_addr    <= '0;
      idx_q       <= '0;
      prog_last_q <= '0;
    end else begin
      done <= hs && finish;
      if (start && !busy)
        cfg_err <= cfg_bad;
      if (launch) begin
        busy        <= 1'b1;
        cur_addr    <= '0;
        idx_q       <= '0;
        prog_last_q <= cfg_prog_last;
      end else if (hs) begin
        idx_q <= idx_q + IDX_W'(1);
        if (finish)
          busy <= 1'b0;
        else
          cur_addr <= next_addr;
      end
    end
  end

  assign vec_valid = busy;
  assign vec_addr  = cur_addr;
  assign vec_idx   = idx_q;

  nvs_capture #(
    .VEC_W(VEC_W), .IDX_W(IDX_W), .CAP_DEPTH(CAP_DEPTH), .CAP_AW(CAP_AW)
  ) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (launch),
    .in_valid (cap_valid),
    .in_data  (cap_data),
    .in_idx   (cap_idx),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_idx   (wr_idx)
  );

endmodule

// File: rtl/nested_vec_seq_chk.sv
module nested_vec_seq_chk #(
  parameter int ADDR_W    = 8,
  parameter int IDX_W     = 16,
  parameter int CAP_DEPTH = 12,
  parameter int CAP_AW    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              cfg_err,
  input logic              vec_valid,
  input logic              vec_ready,
  input logic [ADDR_W-1:0] vec_addr,
  input logic [IDX_W-1:0]  vec_idx,
  input logic              hs,
  input logic              finish,
  input logic [ADDR_W-1:0] prog_last_q,
  input logic              wr_en,
  input logic [CAP_AW-1:0] wr_addr
);

  // R7: a stalled vector is held unchanged
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_addr) && $stable(vec_idx)));

  // R6: each transfer advances the index by one when the run continues
  a_r6_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready) |=> (!vec_valid || (vec_idx == $past(vec_idx) + IDX_W'(1))));

  // R8: done is a lone pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: done follows the final transfer and the stream is idle
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(hs && finish) && !busy && !vec_valid));

  // R9: a refused configuration leaves the block idle
  a_r9_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy);

  // R2: addresses never run past the program end
  a_r2_addr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_addr <= prog_last_q));

  // R10: the capture slot stays inside the store
  a_r10_wr_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_addr) < CAP_DEPTH));

  // R11: start during a run does not stop or restart it
  a_r11_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(hs && finish)) |=> (busy && vec_idx >= $past(vec_idx)));

endmodule

bind nested_vec_seq nested_vec_seq_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CAP_DEPTH(CAP_DEPTH), .CAP_AW(CAP_AW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .cfg_err     (cfg_err),
  .vec_valid   (vec_valid),
  .vec_ready   (vec_ready),
  .vec_addr    (vec_addr),
  .vec_idx     (vec_idx),
  .hs          (hs),
  .finish      (finish),
  .prog_last_q (prog_last_q),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr)
);

// File: tb/nested_vec_seq_tb.sv
`timescale 1ns/1ps
module nested_vec_seq_tb;

  localparam int ADDR_W = 8, CNT_W = 8, IDX_W = 16, VEC_W = 96, LEVELS = 2, CAP_DEPTH = 12;
  localparam int CAP_AW = $clog2(CAP_DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] prog_last = '0;
  logic [LEVELS-1:0] loop_en = '0;
  logic [LEVELS-1:0][ADDR_W-1:0] loop_first = '0;
  logic [LEVELS-1:0][ADDR_W-1:0] loop_last = '0;
  logic [LEVELS-1:0][CNT_W-1:0] loop_count = '0;
  logic busy, done, cfg_err, vec_valid, wr_en;
  logic vec_ready = 1'b0;
  logic [ADDR_W-1:0] vec_addr;
  logic [IDX_W-1:0] vec_idx, wr_idx;
  logic cap_valid = 1'b0;
  logic [VEC_W-1:0] cap_data = '0;
  logic [IDX_W-1:0] cap_idx = '0;
  logic [CAP_AW-1:0] wr_addr;
  logic [VEC_W-1:0] wr_data;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  nested_vec_seq #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .VEC_W(VEC_W),
    .LEVELS(LEVELS), .CAP_DEPTH(CAP_DEPTH)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_prog_last(prog_last), .cfg_loop_en(loop_en),
    .cfg_loop_first(loop_first), .cfg_loop_last(loop_last), .cfg_loop_count(loop_count),
    .busy(busy), .done(done), .cfg_err(cfg_err),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_addr(vec_addr), .vec_idx(vec_idx),
    .cap_valid(cap_valid), .cap_data(cap_data), .cap_idx(cap_idx),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_idx(wr_idx)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int cnt(input int c);
    return (c == 0) ? 1 : c;
  endfunction

  // push one pass of the inner span
  function automatic void push_inner();
    for (int p = 0; p < cnt(int'(loop_count[0])); p++)
      for (int b = int'(loop_first[0]); b <= int'(loop_last[0]); b++) exp_q.push_back(b);
  endfunction

  // expand the program into the flat list of lines it must issue
  function automatic void build_expected();
    exp_q.delete();
    for (int a = 0; a <= int'(prog_last); a++) begin
      if (loop_en[1] && a == int'(loop_first[1])) begin
        for (int p = 0; p < cnt(int'(loop_count[1])); p++) begin
          for (int b = int'(loop_first[1]); b <= int'(loop_last[1]); b++) begin
            if (loop_en[0] && b == int'(loop_first[0])) begin
              push_inner();
              b = int'(loop_last[0]);
            end else exp_q.push_back(b);
          end
        end
        a = int'(loop_last[1]);
      end else if (loop_en[0] && a == int'(loop_first[0])) begin
        push_inner();
        a = int'(loop_last[0]);
      end else exp_q.push_back(a);
    end
  endfunction

  function automatic logic [VEC_W-1:0] sample_of(input int a, input int k);
    return {32'(a) ^ 32'hA5A5_0000, 32'(k), 32'hC0DE_0000 | 32'(k)};
  endfunction

  task automatic set_cfg(input int pl, input int en,
                         input int f0, input int l0, input int c0,
                         input int f1, input int l1, input int c1);
    prog_last = ADDR_W'(pl);
    loop_en = LEVELS'(en);
    loop_first[0] = ADDR_W'(f0); loop_last[0] = ADDR_W'(l0); loop_count[0] = CNT_W'(c0);
    loop_first[1] = ADDR_W'(f1); loop_last[1] = ADDR_W'(l1); loop_count[1] = CNT_W'(c1);
  endtask

  // run one program against the reference; rnd_ready adds backpressure,
  // poke_at > 0 applies a start pulse and scrambled configuration mid-run (R11)
  task automatic run_prog(input string tag, input bit rnd_ready, input int poke_at);
    int k = 0;
    int cyc = 0;
    int exp_ptr = 0;
    bit prev_cap = 1'b0;
    bit prev_last = 1'b0;
    bit seen_done = 1'b0;
    int cap_k = 0;
    int cap_a = 0;
    logic [LEVELS-1:0][ADDR_W-1:0] save_first;
    build_expected();
    save_first = loop_first;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cfg_err == 1'b0, "R9", {tag, " cfg_err after good start"}, cfg_err, 0);
    while (!seen_done && cyc < 5000) begin
      chk(done == prev_last, prev_last ? "R8" : "R8", {tag, " done timing"}, done, prev_last);
      if (prev_cap) begin
        chk(wr_en == 1'b1, "R10", {tag, " wr_en"}, wr_en, 1);
        chk(int'(wr_addr) == exp_ptr, "R10", {tag, " wr_addr"}, wr_addr, exp_ptr);
        chk(int'(wr_idx) == cap_k, "R10", {tag, " wr_idx"}, wr_idx, cap_k);
        chk(wr_data == sample_of(cap_a, cap_k), "R10", {tag, " wr_data"}, wr_data[31:0],
            sample_of(cap_a, cap_k) & 64'hFFFF_FFFF);
        exp_ptr = (exp_ptr + 1 == CAP_DEPTH) ? 0 : exp_ptr + 1;
      end else begin
        chk(wr_en == 1'b0, "R10", {tag, " idle wr_en"}, wr_en, 0);
      end
      if (done) begin
        seen_done = 1'b1;
        chk(busy == 1'b0 && vec_valid == 1'b0, "R8", {tag, " idle at done"}, busy, 0);
        chk(k == exp_q.size(), "R2", {tag, " vector count"}, k, exp_q.size());
      end else begin
        if (k < exp_q.size()) begin
          chk(vec_valid == 1'b1, "R7", {tag, " valid while pending"}, vec_valid, 1);
          chk(int'(vec_addr) == exp_q[k], "R3", {tag, " address order"}, vec_addr, exp_q[k]);
          chk(int'(vec_idx) == k, "R6", {tag, " index"}, vec_idx, k);
        end else begin
          chk(vec_valid == 1'b0, "R2", {tag, " extra vector"}, vec_valid, 0);
        end
      end
      // drive for the coming edge
      start = (poke_at > 0 && cyc == poke_at);
      if (poke_at > 0 && cyc == poke_at) begin
        loop_first[0] = ADDR_W'(int'(loop_first[0]) + 1);
        loop_first[1] = '0;
      end else if (poke_at > 0 && cyc == poke_at + 1) begin
        loop_first = save_first;
      end
      vec_ready = seen_done ? 1'b0 : (rnd_ready ? ($urandom_range(0, 3) != 0) : 1'b1);
      prev_cap = vec_valid && vec_ready && !seen_done;
      cap_valid = prev_cap;
      cap_k = int'(vec_idx);
      cap_a = int'(vec_addr);
      cap_idx = vec_idx;
      cap_data = sample_of(cap_a, cap_k);
      prev_last = prev_cap && (k == exp_q.size() - 1);
      if (prev_cap) k++;
      cyc++;
      if (!seen_done) @(negedge clk);
    end
    if (!seen_done) chk(1'b0, "R8", {tag, " done never seen"}, 0, 1);
    start = 1'b0;
    cap_valid = 1'b0;
    vec_ready = 1'b0;
    loop_first = save_first;
  endtask

  task automatic bad_start(input string tag);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(cfg_err == 1'b1, "R9", {tag, " cfg_err"}, cfg_err, 1);
      chk(busy == 1'b0 && vec_valid == 1'b0, "R9", {tag, " stays idle"}, busy, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(vec_valid == 1'b0, "R1", "vec_valid", vec_valid, 0);
    chk(done == 1'b0, "R1", "done", done, 0);
    chk(cfg_err == 1'b0, "R1", "cfg_err", cfg_err, 0);
    chk(wr_en == 1'b0, "R1", "wr_en", wr_en, 0);

    // R2 straight program
    set_cfg(5, 0, 0, 0, 0, 0, 0, 0);
    run_prog("R2 linear", 1'b0, 0);
    // R3 inner loop with backpressure (R7)
    set_cfg(7, 1, 2, 4, 3, 0, 0, 0);
    run_prog("R3 inner x3", 1'b1, 0);
    // R3 outer level alone
    set_cfg(6, 2, 0, 0, 0, 1, 3, 2);
    run_prog("R3 outer x2", 1'b1, 0);
    // R4 zero count
    set_cfg(4, 1, 1, 3, 0, 0, 0, 0);
    run_prog("R4 count0", 1'b0, 0);
    // R5 nested
    set_cfg(8, 3, 2, 3, 3, 1, 6, 2);
    run_prog("R5 nested", 1'b1, 0);
    // R5 shared end line
    set_cfg(5, 3, 3, 4, 2, 0, 4, 2);
    run_prog("R5 shared end", 1'b1, 0);
    // R11 start and config change mid-run
    set_cfg(9, 3, 4, 5, 2, 2, 7, 2);
    run_prog("R11 poke", 1'b1, 5);

    // R9 refused configurations
    set_cfg(6, 1, 4, 2, 1, 0, 0, 0);
    bad_start("R9 first>last");
    set_cfg(6, 3, 1, 5, 1, 2, 4, 1);
    bad_start("R9 not nested");
    set_cfg(3, 2, 0, 0, 0, 1, 5, 1);
    bad_start("R9 beyond end");
    set_cfg(3, 0, 0, 0, 0, 0, 0, 0);
    run_prog("R9 recover", 1'b0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule